// File: doc/BRIEF.md
# Power-On Strap Sampling Sequencer

This block lets five package pins serve two purposes. Right after the supply is reported good, the five pins act as configuration inputs. Their drivers stay in high impedance for a fixed window, so external pull resistors can set each pin level. When the window closes, the levels are captured into a strap register. In the same clock cycle all five output drivers are enabled, and from then on the pins carry clocks.

The captured straps give a four-bit frequency select and a mode bit. The mode bit decides the role of a sixth shared pin. With mode 1 the pin drives the reference clock. With mode 0 the pin is an active-low CPU stop input, which the block samples and passes on. A done flag goes high together with the driver enables, and downstream logic uses it to qualify the strap values.

The strap register can be cleared only by the power-on reset. Once it is loaded, changes on the supply-good input and on the pins have no effect on it. An undriven pin takes a fixed default: 0 for frequency-select bit 3, and 1 for the other four straps. The window length is a parameter counted in reference-clock cycles.

Top module: `strap_sampler`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pin_oe` is 0, `straps_done` is 0, `fsel` is 0, `mode` is 0, `shared_oe` is 0 and `cpu_stop_n` is 1.
- R2: While `supply_good` stays low, `pin_oe` and `straps_done` stay 0 for any length of time.
- R3: Let edge E be the first rising edge at which `supply_good` is sampled high. `straps_done` and `pin_oe` are still 0 after edge E+WIN_CYCLES-1. Both change after edge E+WIN_CYCLES.
- R4: The strap word is taken from the pin levels present at edge E+WIN_CYCLES. Pin bits 0 to 3 go to `fsel[0]` to `fsel[3]`, and pin bit 4 goes to `mode`.
- R5: A pin whose `pin_float` bit is 1 is captured at its default: 0 for bit 3, and 1 for bits 0, 1, 2 and 4. In that case the value on `pin_lvl` for that bit is ignored.
- R6: If `supply_good` is sampled low before the window ends, the timer starts again. The full window is then counted from the next edge at which `supply_good` is sampled high.
- R7: Once `straps_done` is 1, the values of `fsel` and `mode` do not change for any later `pin_lvl`, `pin_float` or `supply_good` values. They change only through `rst`.
- R8: `straps_done` and all five `pin_oe` bits change in the same cycle. `pin_oe` is always either all zeros or all ones.
- R9: With `straps_done` 1 and `mode` 1, `shared_oe` is 1 and `cpu_stop_n` stays 1 whatever the level on `shared_in`.
- R10: With `straps_done` 1 and `mode` 0, `shared_oe` is 0 and `cpu_stop_n` shows the level that `shared_in` had at the previous rising edge. Before `straps_done`, `cpu_stop_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high power-on reset; the only thing that clears the straps |
| supply_good | input | 1 | Supply-good indication that starts the sampling window |
| pin_lvl | input | 5 | Levels seen on the five dual-purpose pins (bit 4 is mode, bits 3:0 are frequency select) |
| pin_float | input | 5 | Per-pin marker that the pin is left undriven |
| shared_in | input | 1 | Level on the shared pin when it acts as the CPU stop input |
| pin_oe | output | 5 | Output-driver enables of the five dual-purpose pins; 0 means high impedance |
| straps_done | output | 1 | Straps captured and drivers enabled |
| fsel | output | 4 | Captured frequency-select bits |
| mode | output | 1 | Captured mode bit |
| shared_oe | output | 1 | Shared pin drives the reference clock |
| cpu_stop_n | output | 1 | Registered active-low CPU stop request |

## Verification
The bench lets edge E be the first rising edge that samples `supply_good` high. It checks that the drivers are still off after edge E+WIN_CYCLES-1 and on after edge E+WIN_CYCLES. The pins carry a decoy pattern for most of the window, and the real pattern is applied only between those two edges, so a capture one cycle early or late returns the wrong word. `cpu_stop_n` is due one edge after `shared_in` changes, and it is checked on that edge. All inputs are driven on the falling edge and every output is read on the falling edge, half a period after the rising edge that updates it. The strap sweep covers all 32 level patterns and all 32 float masks.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int N_PINS   = 5;
  localparam int FS_BITS  = 4;
  localparam int MODE_IDX = 4;

  // Value taken by an undriven pin: bit 3 is pulled low, the others high.
  localparam logic [N_PINS-1:0] FLOAT_DEFAULT = 5'b10111;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic               mode;
    logic [FS_BITS-1:0] fsel;
  } strap_word_t;

endpackage

// File: rtl/strap_win_timer.sv
module strap_win_timer
  import strap_pkg::*;
#(
  parameter int WIN_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_good,
  output logic capture,
  output logic done
);

  localparam int CW = $clog2(WIN_CYCLES + 1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;

  // The capture strobe fires on the edge that ends the window.
  assign capture = (state_q == SEQ_WAIT) && supply_good && (cnt_q == CW'(WIN_CYCLES));
  assign done    = (state_q == SEQ_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (supply_good) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= CW'(1);
          end
        end
        SEQ_WAIT: begin
          if (!supply_good) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
          end else if (capture) begin
            state_q <= SEQ_DONE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        SEQ_DONE: state_q <= SEQ_DONE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int                NP      = N_PINS,
  parameter logic [NP-1:0]     DEF_VAL = FLOAT_DEFAULT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [NP-1:0] pin_lvl,
  input  logic [NP-1:0] pin_float,
  output logic [NP-1:0] straps
);

  logic [NP-1:0] resolved;

  // Undriven pins fall back to their pull value.
  for (genvar i = 0; i < NP; i++) begin : g_res
    assign resolved[i] = pin_float[i] ? DEF_VAL[i] : pin_lvl[i];
  end

  always_ff @(posedge clk) begin
    if (rst)          straps <= '0;
    else if (capture) straps <= resolved;
  end

endmodule

// File: rtl/strap_shared_pin.sv
module strap_shared_pin (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic mode,
  input  logic shared_in,
  output logic shared_oe,
  output logic cpu_stop_n
);

  assign shared_oe = done & mode;

  // Stop request passes only when the pin is configured as an input.
  always_ff @(posedge clk) begin
    if (rst)                cpu_stop_n <= 1'b1;
    else if (done && !mode) cpu_stop_n <= shared_in;
    else                    cpu_stop_n <= 1'b1;
  end

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int WIN_CYCLES = 28636
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_good,
  input  logic [N_PINS-1:0] pin_lvl,
  input  logic [N_PINS-1:0] pin_float,
  input  logic              shared_in,
  output logic [N_PINS-1:0] pin_oe,
  output logic              straps_done,
  output logic [FS_BITS-1:0] fsel,
  output logic              mode,
  output logic              shared_oe,
  output logic              cpu_stop_n
);

  logic          capture;
  logic          done;
  logic [N_PINS-1:0] straps;
  strap_word_t   word;
  logic [N_PINS-1:0] oe_q;

  strap_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .supply_good (supply_good),
    .capture     (capture),
    .done        (done)
  );

  strap_capture #(.NP(N_PINS), .DEF_VAL(FLOAT_DEFAULT)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .pin_lvl   (pin_lvl),
    .pin_float (pin_float),
    .straps    (straps)
  );

  // Drivers come on at the capture edge, together with done.
  always_ff @(posedge clk) begin
    if (rst)          oe_q <= '0;
    else if (capture) oe_q <= '1;
  end

  assign word        = strap_word_t'(straps);
  assign fsel        = word.fsel;
  assign mode        = word.mode;
  assign pin_oe      = oe_q;
  assign straps_done = done;

  strap_shared_pin u_shared (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .mode       (word.mode),
    .shared_in  (shared_in),
    .shared_oe  (shared_oe),
    .cpu_stop_n (cpu_stop_n)
  );

endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_good,
  input logic [4:0] pin_oe,
  input logic       straps_done,
  input logic [3:0] fsel,
  input logic       mode,
  input logic       shared_oe,
  input logic       cpu_stop_n
);

  AST_HIZ_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    !straps_done |-> (pin_oe == 5'b00000));  // R3

  AST_OE_ALL_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    straps_done |-> (pin_oe == 5'b11111));  // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    straps_done |=> straps_done);  // R7

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (straps_done && $past(straps_done)) |-> ($stable(fsel) && $stable(mode)));  // R7

  AST_DONE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(straps_done) |-> $past(supply_good));  // R6

  AST_SHARED_DIR: assert property (@(posedge clk) disable iff (rst)
    shared_oe |-> (straps_done && mode));  // R9

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!straps_done || shared_oe) |=> cpu_stop_n);  // R10

endmodule

bind strap_sampler strap_sampler_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_good (supply_good),
  .pin_oe      (pin_oe),
  .straps_done (straps_done),
  .fsel        (fsel),
  .mode        (mode),
  .shared_oe   (shared_oe),
  .cpu_stop_n  (cpu_stop_n)
);

// File: tb/sim_strap_sampler.sv
`timescale 1ns/1ps
module sim_strap_sampler;

  localparam int WIN = 8;
  localparam logic [4:0] DEFV = 5'b10111;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_good = 1'b0;
  logic [4:0] pin_lvl = '0;
  logic [4:0] pin_float = '0;
  logic       shared_in = 1'b1;
  logic [4:0] pin_oe;
  logic       straps_done;
  logic [3:0] fsel;
  logic       mode;
  logic       shared_oe;
  logic       cpu_stop_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  strap_sampler #(.WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst(rst), .supply_good(supply_good), .pin_lvl(pin_lvl),
    .pin_float(pin_float), .shared_in(shared_in), .pin_oe(pin_oe),
    .straps_done(straps_done), .fsel(fsel), .mode(mode),
    .shared_oe(shared_oe), .cpu_stop_n(cpu_stop_n)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; supply_good = 1'b0; shared_in = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  // Runs one full window; the real pattern appears only just before the capture edge.
  task automatic run_window(input logic [4:0] lvl, input logic [4:0] flt);
    logic [4:0] exp_w;
    exp_w = (flt & DEFV) | (~flt & lvl);
    pin_float = flt;
    pin_lvl = ~lvl;
    shared_in = 1'b0;
    supply_good = 1'b1;
    tick();                       // edge E
    repeat (WIN - 1) tick();      // edge E+WIN-1
    chk("R3 not done before window end", {31'd0, straps_done}, 32'd0);
    chk("R3 drivers off before window end", {27'd0, pin_oe}, 32'd0);
    chk("R10 stop idle before done", {31'd0, cpu_stop_n}, 32'd1);
    pin_lvl = lvl;
    tick();                       // edge E+WIN
    chk("R3 done at window end", {31'd0, straps_done}, 32'd1);
    chk("R8 drivers on with done", {27'd0, pin_oe}, 32'h1f);
    chk(flt == 5'd0 ? "R4 captured word" : "R5 float default",
        {27'd0, mode, fsel}, {27'd0, exp_w});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 oe", {27'd0, pin_oe}, 32'd0);
    chk("R1 done", {31'd0, straps_done}, 32'd0);
    chk("R1 straps", {27'd0, mode, fsel}, 32'd0);
    chk("R1 shared_oe", {31'd0, shared_oe}, 32'd0);
    chk("R1 stop", {31'd0, cpu_stop_n}, 32'd1);

    // R2 supply never good
    repeat (50) tick();
    chk("R2 still hiz", {27'd0, pin_oe}, 32'd0);
    chk("R2 not done", {31'd0, straps_done}, 32'd0);

    // R4 and R7 to R10 over every level pattern
    for (int p = 0; p < 32; p++) begin
      logic [4:0] w;
      w = 5'(p);
      do_reset();
      run_window(w, 5'd0);
      pin_lvl = ~w; pin_float = 5'h1f; supply_good = 1'b0;
      repeat (3) tick();
      supply_good = 1'b1;
      repeat (2) tick();
      chk("R7 straps frozen", {27'd0, mode, fsel}, {27'd0, w});
      chk("R7 still done", {31'd0, straps_done}, 32'd1);
      if (w[4]) begin
        chk("R9 shared drives", {31'd0, shared_oe}, 32'd1);
        shared_in = 1'b0; tick();
        chk("R9 stop ignored", {31'd0, cpu_stop_n}, 32'd1);
      end else begin
        chk("R10 shared input", {31'd0, shared_oe}, 32'd0);
        shared_in = 1'b0; tick();
        chk("R10 stop low", {31'd0, cpu_stop_n}, 32'd0);
        shared_in = 1'b1; tick();
        chk("R10 stop high", {31'd0, cpu_stop_n}, 32'd1);
      end
    end

    // R5 every float mask against the opposite of the defaults
    for (int f = 0; f < 32; f++) begin
      do_reset();
      run_window(~DEFV, 5'(f));
    end

    // R6 supply drops mid-window, timer restarts
    do_reset();
    pin_float = 5'd0; pin_lvl = 5'b00101;
    supply_good = 1'b1;
    repeat (WIN - 2) tick();
    supply_good = 1'b0;
    tick();
    chk("R6 no done after drop", {31'd0, straps_done}, 32'd0);
    supply_good = 1'b1;
    tick();                        // new edge E
    repeat (WIN - 1) tick();
    chk("R6 restarted window not done", {31'd0, straps_done}, 32'd0);
    chk("R6 drivers still off", {27'd0, pin_oe}, 32'd0);
    tick();
    chk("R6 done after full window", {31'd0, straps_done}, 32'd1);
    chk("R6 straps", {27'd0, mode, fsel}, 32'h05);

    // R7 only reset clears
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R7 reset clears straps", {27'd0, mode, fsel}, 32'd0);
    chk("R7 reset clears done", {31'd0, straps_done}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule